// File: doc/BRIEF.md
# Eight-bit ALU with per-operation flag update

This block is the byte datapath of a small 8-bit processor core. Each cycle it takes one operation code and two byte operands. It returns the byte result at once, without a clock edge. It also holds a six-bit status word, which is written on the clock edge that accepts the operation. Each operation writes only its own fixed subset of status bits and leaves the others as they were. The block shows that subset on `flag_upd` and shows on `res_we` whether the result is meant to be written back. The carry and zero bits used by carry-chained operations come from the stored status word. Because of this, multi-byte add, subtract and compare sequences can be run one byte per cycle.

Two word operations add a zero-extended 8-bit immediate to a 16-bit register pair, or subtract it from the pair. They take two clocks. The first clock handles the low byte. The second clock folds the carry or borrow into the high byte and writes the status word. While the second cycle runs, `busy` is high and any new operation is ignored.

Top module: `alu8_core`

## Requirements
- R1: After reset, `status` is zero, and `busy` and `word_done` are low.
- R2: ADD, ADC, SUB and NEG produce a + b, a + b + C, a - b and 0x00 - a respectively. Each writes all six status bits. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. H is the carry out of bit 3, or the borrow into it. C is the carry out of bit 7, or the borrow into it. V is signed overflow. N is result bit 7. Z is set when the result is zero.
- R3: SBC and CPC compute a - b - C. Their Z bit is set only when the result is zero and Z was already set.
- R4: CMP and CPC write the status bits exactly as SUB and SBC do, but keep `res_we` low.
- R5: AND, OR and XOR write only Z, N, V and S, and clear V. C and H are kept.
- R6: COM gives 0xFF - a, sets C and clears V. It writes Z, C, N, V and S.
- R7: INC and DEC write only Z, N, V and S. C and H are kept. V is set when INC gives 0x80 or DEC gives 0x7F.
- R8: LSL fills bit 0 with zero, and LSR fills bit 7 with zero. ASR keeps bit 7. C takes the bit shifted out, and V = N xor C. Z, C, N, V and S are written.
- R9: ROL moves the stored C into bit 0 and bit 7 into C. ROR moves the stored C into bit 7 and bit 0 into C. Flags are written as in R8.
- R10: SWAP exchanges the two nibbles and changes no status bit.
- R11: The S bit always equals N xor V.
- R12: A word operation accepted in one cycle raises `busy` for the next cycle. At the end of that next cycle, the block presents the 16-bit result with a one-cycle `word_done` pulse and writes Z, C, N, V and S. An operation presented while `busy` is high has no effect.
- R13: An accepted byte operation changes no status bit outside the mask it shows on `flag_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 5 | Operation code. 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 CPC, 6 AND, 7 OR, 8 XOR, 9 COM, 10 NEG, 11 INC, 12 DEC, 13 LSL, 14 LSR, 15 ROL, 16 ROR, 17 ASR, 18 SWAP, 19 word add, 20 word subtract |
| opnd_a | input | 8 | First operand; the low byte of the pair for word operations |
| opnd_b | input | 8 | Second operand; the immediate for word operations |
| pair_hi | input | 8 | High byte of the register pair for word operations |
| res | output | 8 | Byte result (combinational) |
| res_we | output | 1 | The result is to be written back |
| flag_upd | output | 6 | Status bits this accepted byte operation writes |
| status | output | 6 | Registered status word {H,S,V,N,Z,C} |
| busy | output | 1 | Second cycle of a word operation |
| word_res | output | 16 | Registered 16-bit result of the last word operation |
| word_done | output | 1 | One-cycle pulse when `word_res` is updated |

## Verification
Every byte operation is run against a grid of boundary operands: 0x00, 0xFF, 0x7F, 0x80, 0x0F, 0x10, 0x08 and 0x01. These values separate carry from borrow, signed overflow from plain overflow, and half-carry from full carry. A long pseudo-random run follows. In it, the stored carry and zero bits come from whatever the previous operation left, which exercises the chained and retained-bit paths. Directed sequences first set up Z and C and then issue SBC and CPC, which separates the sticky-zero rule from a plain zero test. Word operations are tried at the byte-carry boundary, the signed wrap and the full 16-bit wrap, each with a competing operation presented in the busy cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW    = 8;
  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;
  localparam int WW = 2 * DW;

  localparam logic [NFLAG-1:0] M_ALL   = 6'b111111;
  localparam logic [NFLAG-1:0] M_ZNVS  = 6'b011110;
  localparam logic [NFLAG-1:0] M_ZCNVS = 6'b011111;

  typedef enum logic [4:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC,
    OP_AND, OP_OR, OP_XOR, OP_INV, OP_NEG, OP_INC, OP_DEC,
    OP_SHL, OP_SHR, OP_ROTL, OP_ROTR, OP_ASHR, OP_NSWP,
    OP_WADD, OP_WSUB
  } alu_op_e;

  // returns {half_carry, carry, sum}
  function automatic logic [DW+1:0] add_core(input logic [DW-1:0] x, y, input logic ci);
    logic [4:0]  lo;
    logic [DW:0] full;
    lo   = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0000, ci};
    full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    return {lo[4], full[DW], full[DW-1:0]};
  endfunction

  // returns {half_borrow, borrow, difference}
  function automatic logic [DW+1:0] sub_core(input logic [DW-1:0] x, y, input logic ci);
    logic [4:0]  lo;
    logic [DW:0] full;
    lo   = {1'b0, x[3:0]} - {1'b0, y[3:0]} - {4'b0000, ci};
    full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, ci};
    return {lo[4], full[DW], full[DW-1:0]};
  endfunction
endpackage

// File: rtl/alu8_byte_unit.sv
module alu8_byte_unit
  import alu8_pkg::*;
(
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [NFLAG-1:0] flg_in,
  output logic [DW-1:0]    res,
  output logic             wr,
  output logic [NFLAG-1:0] mask,
  output logic [NFLAG-1:0] flg_new
);
  logic [DW+1:0] hcr;
  logic          h, c, v, n, z, z_sticky;
  logic          c_in;

  assign c_in = flg_in[FC];

  always_comb begin
    hcr      = '0;
    res      = a;
    h        = flg_in[FH];
    c        = flg_in[FC];
    v        = 1'b0;
    wr       = 1'b1;
    mask     = '0;
    z_sticky = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        hcr  = add_core(a, b, (op == OP_ADC) ? c_in : 1'b0);
        {h, c, res} = hcr;
        v    = (a[DW-1] == b[DW-1]) && (res[DW-1] != a[DW-1]);
        mask = M_ALL;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
        hcr  = sub_core(a, b, (op == OP_SBC || op == OP_CMPC) ? c_in : 1'b0);
        {h, c, res} = hcr;
        v    = (a[DW-1] != b[DW-1]) && (res[DW-1] != a[DW-1]);
        mask = M_ALL;
        wr   = !(op == OP_CMP || op == OP_CMPC);
        z_sticky = (op == OP_SBC || op == OP_CMPC);
      end
      OP_NEG: begin
        hcr  = sub_core('0, a, 1'b0);
        {h, c, res} = hcr;
        v    = a[DW-1] && res[DW-1];
        mask = M_ALL;
      end
      OP_AND:  begin res = a & b; mask = M_ZNVS; end
      OP_OR:   begin res = a | b; mask = M_ZNVS; end
      OP_XOR:  begin res = a ^ b; mask = M_ZNVS; end
      OP_INV:  begin res = ~a; c = 1'b1; mask = M_ZCNVS; end
      OP_INC:  begin res = a + 1'b1; v = (res == {1'b1, {(DW-1){1'b0}}}); mask = M_ZNVS; end
      OP_DEC:  begin res = a - 1'b1; v = (res == {1'b0, {(DW-1){1'b1}}}); mask = M_ZNVS; end
      OP_SHL:  begin res = {a[DW-2:0], 1'b0};  c = a[DW-1]; v = res[DW-1] ^ c; mask = M_ZCNVS; end
      OP_SHR:  begin res = {1'b0, a[DW-1:1]};  c = a[0];    v = res[DW-1] ^ c; mask = M_ZCNVS; end
      OP_ROTL: begin res = {a[DW-2:0], c_in};  c = a[DW-1]; v = res[DW-1] ^ c; mask = M_ZCNVS; end
      OP_ROTR: begin res = {c_in, a[DW-1:1]};  c = a[0];    v = res[DW-1] ^ c; mask = M_ZCNVS; end
      OP_ASHR: begin res = {a[DW-1], a[DW-1:1]}; c = a[0];  v = res[DW-1] ^ c; mask = M_ZCNVS; end
      OP_NSWP: begin res = {a[3:0], a[DW-1:4]}; end
      default: begin wr = 1'b0; end
    endcase
    n = res[DW-1];
    z = (res == '0) && (!z_sticky || flg_in[FZ]);
    flg_new        = '0;
    flg_new[FC]    = c;
    flg_new[FZ]    = z;
    flg_new[FN]    = n;
    flg_new[FV]    = v;
    flg_new[FS]    = n ^ v;
    flg_new[FH]    = h;
  end
endmodule

// File: rtl/alu8_word_seq.sv
module alu8_word_seq
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sub,
  input  logic [DW-1:0]    lo,
  input  logic [DW-1:0]    hi,
  input  logic [DW-1:0]    imm,
  output logic             busy,
  output logic [NFLAG-1:0] wflg,
  output logic [WW-1:0]    word_res,
  output logic             word_done
);
  logic [DW-1:0] lo_q, hi_q, hi_new;
  logic          cy_q, sub_q;
  logic [DW:0]   lo_sum;
  logic [WW-1:0] full;
  logic          wn, wv, wc;

  assign lo_sum = sub ? ({1'b0, lo} - {1'b0, imm}) : ({1'b0, lo} + {1'b0, imm});
  assign hi_new = sub_q ? (hi_q - {{(DW-1){1'b0}}, cy_q}) : (hi_q + {{(DW-1){1'b0}}, cy_q});
  assign full   = {hi_new, lo_q};
  assign wn     = hi_new[DW-1];
  assign wv     = sub_q ? (hi_q[DW-1] && !hi_new[DW-1]) : (!hi_q[DW-1] && hi_new[DW-1]);
  assign wc     = sub_q ? (hi_new[DW-1] && !hi_q[DW-1]) : (!hi_new[DW-1] && hi_q[DW-1]);

  always_comb begin
    wflg     = '0;
    wflg[FC] = wc;
    wflg[FZ] = (full == '0);
    wflg[FN] = wn;
    wflg[FV] = wv;
    wflg[FS] = wn ^ wv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; word_done <= 1'b0; word_res <= '0;
      lo_q <= '0; hi_q <= '0; cy_q <= 1'b0; sub_q <= 1'b0;
    end else begin
      word_done <= busy;
      if (busy) begin
        word_res <= full;
        busy     <= 1'b0;
      end else if (start) begin
        lo_q  <= lo_sum[DW-1:0];
        cy_q  <= lo_sum[DW];
        hi_q  <= hi;
        sub_q <= sub;
        busy  <= 1'b1;
      end
    end
  end

  p_word_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_word_finish_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && word_done));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [4:0]       op_sel,
  input  logic [DW-1:0]    opnd_a,
  input  logic [DW-1:0]    opnd_b,
  input  logic [DW-1:0]    pair_hi,
  output logic [DW-1:0]    res,
  output logic             res_we,
  output logic [NFLAG-1:0] flag_upd,
  output logic [NFLAG-1:0] status,
  output logic             busy,
  output logic [WW-1:0]    word_res,
  output logic             word_done
);
  alu_op_e          op;
  logic             is_word, accept, byte_go, word_go, b_wr;
  logic [NFLAG-1:0] b_mask, b_flg, w_flg, status_q;

  assign op      = alu_op_e'(op_sel);
  assign is_word = (op == OP_WADD) || (op == OP_WSUB);
  assign accept  = op_valid && !busy;
  assign byte_go = accept && !is_word;
  assign word_go = accept && is_word;

  alu8_byte_unit u_byte (
    .op(op), .a(opnd_a), .b(opnd_b), .flg_in(status_q),
    .res(res), .wr(b_wr), .mask(b_mask), .flg_new(b_flg)
  );

  alu8_word_seq u_word (
    .clk(clk), .rst_n(rst_n), .start(word_go), .sub(op == OP_WSUB),
    .lo(opnd_a), .hi(pair_hi), .imm(opnd_b),
    .busy(busy), .wflg(w_flg), .word_res(word_res), .word_done(word_done)
  );

  assign res_we   = byte_go && b_wr;
  assign flag_upd = byte_go ? b_mask : '0;
  assign status   = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       status_q <= '0;
    else if (busy)    status_q <= (status_q & ~M_ZCNVS) | (w_flg & M_ZCNVS);
    else if (byte_go) status_q <= (status_q & ~b_mask) | (b_flg & b_mask);
  end

  p_s_is_n_xor_v_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[FS] == (status_q[FN] ^ status_q[FV]));
  p_mask_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> (((status_q ^ $past(status_q)) & ~$past(flag_upd)) == '0));
  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_CMP || op == OP_CMPC)) |-> !res_we);
  p_swap_no_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_go && op == OP_NSWP) |=> $stable(status_q));
  p_incdec_keep_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_go && (op == OP_INC || op == OP_DEC)) |=> (status_q[FC] == $past(status_q[FC])));
  p_busy_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!res_we && flag_upd == '0));
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/100ps
module sim_alu8_core;
  import alu8_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, pair_hi = '0;
  logic [7:0] res;
  logic res_we, busy, word_done;
  logic [5:0] flag_upd, status;
  logic [15:0] word_res;

  int total = 0;
  int bad = 0;
  int flags_m = 0;
  int seed = 32'h1234_5678;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pair_hi(pair_hi),
    .res(res), .res_we(res_we), .flag_upd(flag_upd), .status(status),
    .busy(busy), .word_res(word_res), .word_done(word_done)
  );

  task automatic chk(input bit ok, input string tg, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tg, what, act, exp);
    end
  endtask

  function automatic int sx(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string tag(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_NEG: return "R2";
      OP_SBC:                         return "R3";
      OP_CMP, OP_CMPC:                return "R4";
      OP_AND, OP_OR, OP_XOR:          return "R5";
      OP_INV:                         return "R6";
      OP_INC, OP_DEC:                 return "R7";
      OP_SHL, OP_SHR, OP_ASHR:        return "R8";
      OP_ROTL, OP_ROTR:               return "R9";
      OP_NSWP:                        return "R10";
      default:                        return "R12";
    endcase
  endfunction

  // behavioural model; flag bits C=1 Z=2 N=4 V=8 S=16 H=32
  function automatic void mdl(input alu_op_e op, input int a, input int b, input int fin,
                              output int r, output int we, output int mk, output int fo);
    int ci, t, sv, c, h, v, n, z, nw;
    ci = fin & 1; c = 0; h = 0; v = 0; we = 1; mk = 0; r = a;
    case (op)
      OP_ADD, OP_ADC: begin
        if (op == OP_ADD) ci = 0;
        t = a + b + ci; r = t & 255; c = (t > 255);
        h = (((a & 15) + (b & 15) + ci) > 15);
        sv = sx(a) + sx(b) + ci; v = (sv > 127 || sv < -128); mk = 63;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
        if (op == OP_SUB || op == OP_CMP) ci = 0;
        t = a - b - ci; r = t & 255; c = (t < 0);
        h = (((a & 15) - (b & 15) - ci) < 0);
        sv = sx(a) - sx(b) - ci; v = (sv > 127 || sv < -128); mk = 63;
        if (op == OP_CMP || op == OP_CMPC) we = 0;
      end
      OP_NEG: begin
        t = 0 - a; r = t & 255; c = (t < 0); h = ((0 - (a & 15)) < 0);
        sv = 0 - sx(a); v = (sv > 127); mk = 63;
      end
      OP_AND: begin r = a & b; mk = 30; end
      OP_OR:  begin r = a | b; mk = 30; end
      OP_XOR: begin r = a ^ b; mk = 30; end
      OP_INV: begin r = 255 - a; c = 1; mk = 31; end
      OP_INC: begin r = (a + 1) & 255; v = (a == 127); mk = 30; end
      OP_DEC: begin r = (a + 255) & 255; v = (a == 128); mk = 30; end
      OP_SHL:  begin r = (a * 2) & 255; c = (a >= 128); mk = 31; end
      OP_SHR:  begin r = a / 2; c = a % 2; mk = 31; end
      OP_ROTL: begin r = ((a * 2) & 255) + (fin & 1); c = (a >= 128); mk = 31; end
      OP_ROTR: begin r = a / 2 + 128 * (fin & 1); c = a % 2; mk = 31; end
      OP_ASHR: begin r = a / 2 + (a & 128); c = a % 2; mk = 31; end
      OP_NSWP: begin r = ((a % 16) * 16) + (a / 16); mk = 0; end
      default: begin we = 0; end
    endcase
    n = (r >= 128);
    if (mk == 31 && op != OP_INV) v = n ^ c;
    z = (r == 0);
    if (op == OP_SBC || op == OP_CMPC) z = z && ((fin & 2) != 0);
    nw = c + 2 * z + 4 * n + 8 * v + 16 * (n ^ v) + 32 * h;
    fo = (fin & ~mk) | (nw & mk);
  endfunction

  task automatic do_byte(input alu_op_e op, input int a, input int b);
    int r, we, mk, fo;
    @(negedge clk);
    op_valid = 1'b1; op_sel = 5'(op); opnd_a = 8'(a); opnd_b = 8'(b);
    mdl(op, a, b, flags_m, r, we, mk, fo);
    #1;
    chk(res == 8'(r), tag(op), "result", int'(res), r);
    chk(res_we == we[0], tag(op), "res_we", int'(res_we), we);
    chk(flag_upd == 6'(mk), tag(op), "flag_upd", int'(flag_upd), mk);
    @(negedge clk);
    op_valid = 1'b0;
    flags_m = fo;
    chk(status == 6'(flags_m), {tag(op), "/R13"}, "status", int'(status), flags_m);
    chk(status[4] == (status[2] ^ status[3]), "R11", "S vs N^V", int'(status[4]), int'(status[2] ^ status[3]));
  endtask

  task automatic do_word(input bit sb, input int hi, input int lo, input int imm);
    int pair, t, r, c, v, n, z, sv;
    pair = hi * 256 + lo;
    t = sb ? pair - imm : pair + imm;
    r = t & 65535; c = (t < 0 || t > 65535);
    sv = (pair > 32767 ? pair - 65536 : pair) + (sb ? -imm : imm);
    v = (sv > 32767 || sv < -32768); n = (r >= 32768); z = (r == 0);
    @(negedge clk);
    op_valid = 1'b1; op_sel = sb ? 5'(OP_WSUB) : 5'(OP_WADD);
    pair_hi = 8'(hi); opnd_a = 8'(lo); opnd_b = 8'(imm);
    #1;
    chk(res_we == 1'b0, "R12", "word issue res_we", int'(res_we), 0);
    @(negedge clk);
    chk(busy == 1'b1, "R12", "busy", int'(busy), 1);
    op_sel = 5'(OP_ADD); opnd_a = 8'h55; opnd_b = 8'h55;  // must be ignored
    #1;
    chk(res_we == 1'b0 && flag_upd == 6'd0, "R12", "ignored while busy", int'({res_we, flag_upd}), 0);
    @(negedge clk);
    op_valid = 1'b0;
    chk(busy == 1'b0, "R12", "busy clear", int'(busy), 0);
    chk(word_done == 1'b1, "R12", "word_done", int'(word_done), 1);
    chk(word_res == 16'(r), "R12", "word_res", int'(word_res), r);
    flags_m = (flags_m & 32) | c | 2 * z | 4 * n | 8 * v | 16 * (n ^ v);
    chk(status == 6'(flags_m), "R12", "word status", int'(status), flags_m);
    @(negedge clk);
    chk(word_done == 1'b0, "R12", "word_done pulse", int'(word_done), 0);
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pa[8] = '{0, 255, 128, 127, 15, 16, 8, 1};
    int pb[4] = '{0, 1, 255, 128};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 6'd0, "R1", "reset status", int'(status), 0);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(word_done == 1'b0, "R1", "reset word_done", int'(word_done), 0);

    for (int k = 0; k < 19; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 4; j++)
          do_byte(alu_op_e'(k), pa[i], pb[j]);

    // sticky zero for chained subtract and compare (R3)
    do_byte(OP_SUB, 5, 5);
    do_byte(OP_SBC, 0, 0);
    do_byte(OP_SUB, 5, 4);
    do_byte(OP_CMPC, 0, 0);
    do_byte(OP_SUB, 3, 4);
    do_byte(OP_SBC, 1, 0);
    // carry-through rotations (R9)
    do_byte(OP_INV, 0, 0);
    do_byte(OP_ROTL, 8'h80, 0);
    do_byte(OP_ROTR, 8'h01, 0);
    // S after logic ops and swap (R5, R10)
    do_byte(OP_DEC, 8'h80, 0);
    do_byte(OP_NSWP, 8'hA5, 0);
    do_byte(OP_AND, 8'hF0, 8'h80);

    for (int k = 0; k < 400; k++)
      do_byte(alu_op_e'(rnd() % 19), rnd(), rnd());

    do_word(1'b0, 8'h00, 8'hFF, 1);
    do_word(1'b0, 8'hFF, 8'hFF, 1);
    do_word(1'b0, 8'h7F, 8'hFF, 1);
    do_word(1'b1, 8'h00, 8'h00, 1);
    do_word(1'b1, 8'h80, 8'h00, 1);
    do_word(1'b1, 8'h12, 8'h34, 8'h34);
    for (int k = 0; k < 20; k++)
      do_word(rnd() % 2 == 1, rnd(), rnd(), rnd());
    do_byte(OP_ADC, 8'hFF, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule